// File: doc/BRIEF.md
# Signed Long Multiply-Accumulate Unit

This block forms a signed product from two 32-bit operands and adds it to a 64-bit accumulator. The accumulator arrives as two 32-bit words and the result leaves the same way. A mode input picks one of four product shapes:

- one 32x32 word product;
- one 16x16 product, where each operand contributes either its upper or its lower half;
- the sum of two 16x16 products, pairing halves either straight or crossed.

Every product is sign-extended to 64 bits before it is added. The addition wraps modulo 2^64.

The unit sits in an execution pipeline between operand fetch and write-back. With the default configuration it has one output register stage. An input strobe marks each valid operation, and the matching output strobe rises exactly one clock later. Mode codes that are not assigned return the accumulator unchanged.

Top module: `sacc64_unit`

## Requirements
- R1: With mode 3'b000 (word), the result is acc + sext64(op_a) * sext64(op_b). Both operands are treated as two's complement.
- R2: The accumulator input is {acc_hi, acc_lo} and the result is {res_hi, res_lo}. In both, the low port carries bits [31:0] and the high port carries bits [63:32].
- R3: With mode 3'b001 (halfword), hsel[1] picks the half of op_a and hsel[0] picks the half of op_b, where 0 selects bits [15:0] and 1 selects bits [31:16]. The signed 16x16 product is sign-extended to 64 bits and added to the accumulator.
- R4: In halfword mode, the halves of op_a and op_b that hsel does not select do not affect the result.
- R5: With mode 3'b010 (dual straight), the result is acc + lo(a)*lo(b) + hi(a)*hi(b). Each product is signed and sign-extended to 64 bits.
- R6: With mode 3'b011 (dual crossed), the result is acc + lo(a)*hi(b) + hi(a)*lo(b). Each product is signed and sign-extended to 64 bits.
- R7: The 64-bit sum wraps modulo 2^64. There is no saturation and no overflow indication.
- R8: Mode codes 3'b100 through 3'b111 produce a result equal to the accumulator.
- R9: With REG_OUT=1, the result and out_valid appear one clock after the edge that samples in_valid high. Reset clears out_valid.
- R10: A cycle with in_valid low leaves res_hi and res_lo unchanged and drives out_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released in step with clk |
| in_valid | input | 1 | Marks a valid operation on the inputs |
| mode | input | 3 | Product shape: 0 word, 1 halfword, 2 dual straight, 3 dual crossed, 4-7 pass the accumulator through |
| hsel | input | 2 | Halfword picks: bit 1 for op_a, bit 0 for op_b; 1 selects the upper half |
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand |
| acc_lo | input | 32 | Accumulator bits [31:0] |
| acc_hi | input | 32 | Accumulator bits [63:32] |
| out_valid | output | 1 | Result valid |
| res_lo | output | 32 | Result bits [31:0] |
| res_hi | output | 32 | Result bits [63:32] |

## Verification
A wrong half select or a wrong lane pairing shows up on the very next out_valid as a result that differs from the wide-integer model. A wrong pairing is usually caught because the difference from the accumulator also leaves the 32-bit or 33-bit range that halfword and dual products must stay inside. A dropped sign extension or carry between the two output words appears only for negative products or for wrapping sums, so directed vectors at the most negative operands and at the accumulator edges expose it on their first cycle. A lost clock enable or a stuck valid register is visible one cycle after in_valid falls, as a result that changed or an out_valid that stayed high.

// File: rtl/sacc64_pkg.sv
package sacc64_pkg;
  localparam int unsigned MODE_W = 3;
  localparam logic [MODE_W-1:0] MD_WORD  = 3'd0;
  localparam logic [MODE_W-1:0] MD_HALF  = 3'd1;
  localparam logic [MODE_W-1:0] MD_DUAL  = 3'd2;
  localparam logic [MODE_W-1:0] MD_DUALX = 3'd3;
  localparam int unsigned N_LANE = 2;
  localparam int unsigned N_TERM = N_LANE + 1;
endpackage

// File: rtl/sacc64_opsel.sv
module sacc64_opsel
  import sacc64_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned H = W / 2
) (
  input  logic [MODE_W-1:0]           mode,
  input  logic [1:0]                  hsel,
  input  logic [W-1:0]                op_a,
  input  logic [W-1:0]                op_b,
  output logic [N_LANE-1:0][H-1:0]    lane_a,
  output logic [N_LANE-1:0][H-1:0]    lane_b,
  output logic [N_LANE-1:0]           lane_en,
  output logic                        word_en
);
  logic [H-1:0] a_lo, a_hi, b_lo, b_hi;

  assign a_lo = op_a[H-1:0];
  assign a_hi = op_a[W-1:H];
  assign b_lo = op_b[H-1:0];
  assign b_hi = op_b[W-1:H];

  always_comb begin
    lane_a  = '0;
    lane_b  = '0;
    lane_en = '0;
    word_en = 1'b0;
    unique case (mode)
      MD_WORD: word_en = 1'b1;
      MD_HALF: begin
        lane_a[0]  = hsel[1] ? a_hi : a_lo;
        lane_b[0]  = hsel[0] ? b_hi : b_lo;
        lane_en[0] = 1'b1;
      end
      MD_DUAL: begin
        lane_a[0] = a_lo;
        lane_b[0] = b_lo;
        lane_a[1] = a_hi;
        lane_b[1] = b_hi;
        lane_en   = '1;
      end
      MD_DUALX: begin
        lane_a[0] = a_lo;
        lane_b[0] = b_hi;
        lane_a[1] = a_hi;
        lane_b[1] = b_lo;
        lane_en   = '1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sacc64_mul.sv
module sacc64_mul #(
  parameter int unsigned IW = 16,
  parameter int unsigned OW = 64,
  localparam int unsigned PW = 2 * IW
) (
  input  logic [IW-1:0] x,
  input  logic [IW-1:0] y,
  output logic [OW-1:0] p
);
  logic signed [IW-1:0] xs, ys;
  logic signed [PW-1:0] prod;

  assign xs   = x;
  assign ys   = y;
  assign prod = xs * ys;

  generate
    if (OW > PW) begin : g_ext
      assign p = {{(OW-PW){prod[PW-1]}}, prod};
    end else begin : g_fit
      assign p = prod[OW-1:0];
    end
  endgenerate
endmodule

// File: rtl/sacc64_sum.sv
module sacc64_sum #(
  parameter int unsigned OW = 64,
  parameter int unsigned N  = 3
) (
  input  logic [OW-1:0]         base,
  input  logic [N-1:0][OW-1:0]  term,
  input  logic [N-1:0]          term_en,
  output logic [OW-1:0]         total
);
  always_comb begin
    total = base;
    for (int i = 0; i < N; i++) begin
      if (term_en[i]) total = total + term[i];
    end
  end
endmodule

// File: rtl/sacc64_unit.sv
module sacc64_unit
  import sacc64_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned H  = W / 2,
  localparam int unsigned DW = 2 * W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MODE_W-1:0] mode,
  input  logic [1:0]        hsel,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [W-1:0]      acc_lo,
  input  logic [W-1:0]      acc_hi,
  output logic              out_valid,
  output logic [W-1:0]      res_lo,
  output logic [W-1:0]      res_hi
);
  logic [N_LANE-1:0][H-1:0]  lane_a, lane_b;
  logic [N_LANE-1:0]         lane_en;
  logic                      word_en;
  logic [N_TERM-1:0][DW-1:0] term;
  logic [N_TERM-1:0]         term_en;
  logic [DW-1:0]             sum;

  sacc64_opsel #(.W(W)) u_opsel (
    .mode    (mode),
    .hsel    (hsel),
    .op_a    (op_a),
    .op_b    (op_b),
    .lane_a  (lane_a),
    .lane_b  (lane_b),
    .lane_en (lane_en),
    .word_en (word_en)
  );

  sacc64_mul #(.IW(W), .OW(DW)) u_mul_word (
    .x (op_a),
    .y (op_b),
    .p (term[N_LANE])
  );

  generate
    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
      sacc64_mul #(.IW(H), .OW(DW)) u_mul_half (
        .x (lane_a[g]),
        .y (lane_b[g]),
        .p (term[g])
      );
    end
  endgenerate

  assign term_en = {word_en, lane_en};

  sacc64_sum #(.OW(DW), .N(N_TERM)) u_sum (
    .base    ({acc_hi, acc_lo}),
    .term    (term),
    .term_en (term_en),
    .total   (sum)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [DW-1:0] res_q, res_d;
      logic          vld_q, vld_d;

      always_comb begin
        res_d = in_valid ? sum : res_q;
        vld_d = in_valid;
      end

      always_ff @(posedge clk) begin
        res_q <= res_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_d;
      end

      assign {res_hi, res_lo} = res_q;
      assign out_valid        = vld_q;
    end else begin : g_comb
      assign {res_hi, res_lo} = sum;
      assign out_valid        = in_valid;
    end
  endgenerate
endmodule

// File: rtl/sacc64_chk.sv
module sacc64_chk
  import sacc64_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned DW = 2 * W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [MODE_W-1:0] mode,
  input logic [1:0]        hsel,
  input logic [W-1:0]      op_a,
  input logic [W-1:0]      op_b,
  input logic [W-1:0]      acc_lo,
  input logic [W-1:0]      acc_hi,
  input logic              out_valid,
  input logic [W-1:0]      res_lo,
  input logic [W-1:0]      res_hi
);
  logic              seen, loaded;
  logic [DW-1:0]     acc_v, diff;
  logic [MODE_W-1:0] mode_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      loaded <= 1'b0;
    end else begin
      seen   <= 1'b1;
      if (in_valid) loaded <= 1'b1;
    end
  end

  generate
    if (REG_OUT) begin : g_cap
      always_ff @(posedge clk) begin
        if (in_valid) begin
          acc_v  <= {acc_hi, acc_lo};
          mode_v <= mode;
        end
      end
    end else begin : g_pass
      assign acc_v  = {acc_hi, acc_lo};
      assign mode_v = mode;
    end
  endgenerate

  assign diff = {res_hi, res_lo} - acc_v;

  // R8
  unused_mode_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_v[MODE_W-1]) |-> ({res_hi, res_lo} == acc_v));

  // R3
  half_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_v == MD_HALF) |-> (diff[DW-1:W-1] == '0 || diff[DW-1:W-1] == '1));

  // R5
  dual_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (mode_v == MD_DUAL || mode_v == MD_DUALX))
      |-> (diff[DW-1:W] == '0 || diff[DW-1:W] == '1));

  generate
    if (REG_OUT) begin : g_seq
      // R9
      valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (out_valid == $past(in_valid)));

      // R9
      reset_valid_chk: assert property (@(posedge clk)
        !rst_n |-> !out_valid);

      // R10
      hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && !in_valid) |=> $stable({res_hi, res_lo}));
    end
  endgenerate
endmodule

bind sacc64_unit sacc64_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_sacc64_unit.sv
`timescale 1ns/1ps
module tb_sacc64_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  mode;
  logic [1:0]  hsel;
  logic [31:0] op_a, op_b, acc_lo, acc_hi;
  logic        out_valid;
  logic [31:0] res_lo, res_hi;

  int    vecs = 0;
  int    errs = 0;
  bit    done = 1'b0;
  bit    pend = 1'b0;
  logic [63:0] exp_q;
  string exp_tag;

  always #4 clk = ~clk;

  sacc64_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .hsel(hsel),
    .op_a(op_a), .op_b(op_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
    .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi)
  );

  function automatic logic [63:0] model(logic [2:0] m, logic [1:0] hs,
                                        logic [31:0] a, logic [31:0] b, logic [63:0] acc);
    longint  p;
    shortint al, ah, bl, bh, xa, xb;
    al = shortint'(a[15:0]);  ah = shortint'(a[31:16]);
    bl = shortint'(b[15:0]);  bh = shortint'(b[31:16]);
    case (m)
      3'd0: p = longint'(int'(a)) * longint'(int'(b));
      3'd1: begin
        xa = hs[1] ? ah : al;
        xb = hs[0] ? bh : bl;
        p  = longint'(xa) * longint'(xb);
      end
      3'd2: p = longint'(al) * longint'(bl) + longint'(ah) * longint'(bh);
      3'd3: p = longint'(al) * longint'(bh) + longint'(ah) * longint'(bl);
      default: p = 0;
    endcase
    return acc + 64'(p);
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic settle_pending();
    if (pend) begin
      check({exp_tag, " out_valid"}, {63'd0, out_valid}, 64'd1);
      check(exp_tag, {res_hi, res_lo}, exp_q);
      pend = 1'b0;
    end
  endtask

  task automatic apply(logic [2:0] m, logic [1:0] hs, logic [31:0] a, logic [31:0] b,
                       logic [63:0] acc, string tag);
    @(negedge clk);
    settle_pending();
    in_valid = 1'b1;
    mode = m; hsel = hs; op_a = a; op_b = b;
    {acc_hi, acc_lo} = acc;
    exp_q   = model(m, hs, a, b, acc);
    exp_tag = tag;
    pend    = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    logic [31:0] ra, rb;
    void'($urandom(32'h5A1C_0F3B));
    rst_n = 1'b0; in_valid = 1'b0; mode = '0; hsel = '0;
    op_a = '0; op_b = '0; acc_lo = '0; acc_hi = '0;
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle out_valid", {63'd0, out_valid}, 64'd0);

    // R1 word corners
    apply(3'd0, 2'b00, 32'h8000_0000, 32'h8000_0000, 64'd0, "R1 minneg sq");
    apply(3'd0, 2'b00, 32'h8000_0000, 32'h7FFF_FFFF, 64'd5, "R1 minneg*max");
    apply(3'd0, 2'b11, 32'hFFFF_FFFF, 32'h0000_0003, 64'd10, "R1 neg small");
    // R2 word split: carry into high word
    apply(3'd0, 2'b00, 32'h0000_0001, 32'h0000_0001, 64'h0000_0000_FFFF_FFFF, "R2 carry lo->hi");
    apply(3'd0, 2'b00, 32'hFFFF_FFFF, 32'h0000_0001, 64'h0000_0001_0000_0000, "R2 borrow hi->lo");
    // R7 wrap
    apply(3'd0, 2'b00, 32'd1, 32'd1, 64'h7FFF_FFFF_FFFF_FFFF, "R7 wrap posmax");
    apply(3'd0, 2'b00, 32'd1, 32'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R7 wrap to zero");
    apply(3'd2, 2'b00, 32'h8000_8000, 32'h8000_8000, 64'hFFFF_FFFF_8000_0000, "R7 dual wrap");
    // R3 all four half picks
    for (int s = 0; s < 4; s++)
      apply(3'd1, 2'(s), 32'h8001_7FFF, 32'hFFFE_8000, 64'h0123_4567_89AB_CDEF, "R3 half pick");
    // R4 unselected halves: same selected halves, scrambled others
    apply(3'd1, 2'b10, 32'h8001_0000, 32'h1234_7FFF, 64'd0, "R4 base");
    apply(3'd1, 2'b10, 32'h8001_FFFF, 32'hABCD_7FFF, 64'd0, "R4 scramble1");
    apply(3'd1, 2'b01, 32'h5555_8000, 32'h8000_AAAA, 64'd7, "R4 scramble2");
    // R5 dual straight, R6 dual crossed
    apply(3'd2, 2'b11, 32'h7FFF_8000, 32'h7FFF_8000, 64'd0, "R5 dual straight");
    apply(3'd2, 2'b00, 32'h0003_FFFE, 32'hFFF9_0005, 64'd100, "R5 dual mixed");
    apply(3'd3, 2'b00, 32'h0003_FFFE, 32'hFFF9_0005, 64'd100, "R6 dual crossed");
    apply(3'd3, 2'b10, 32'h8000_7FFF, 32'h8000_7FFF, 64'hDEAD_BEEF_0000_0001, "R6 crossed extremes");
    // R8 unused codes
    for (int m = 4; m < 8; m++)
      apply(3'(m), 2'b11, 32'hFFFF_FFFF, 32'h8000_0001, 64'hCAFE_F00D_1234_5678, "R8 unused mode");

    // R10 hold with in_valid low
    apply(3'd0, 2'b00, 32'd9, 32'd7, 64'd1, "R10 load");
    held = 64'd64;
    @(negedge clk);
    settle_pending();
    in_valid = 1'b0;
    op_a = 32'h1111_2222; op_b = 32'h3333_4444; mode = 3'd0;
    @(negedge clk);
    check("R10 hold result", {res_hi, res_lo}, held);
    check("R10 valid low", {63'd0, out_valid}, 64'd0);

    // random mix: R1 R3 R5 R6 R8
    for (int i = 0; i < 3000; i++) begin
      ra = $urandom;
      rb = $urandom;
      apply(3'($urandom % 8), 2'($urandom % 4), ra, rb, {32'($urandom), 32'($urandom)},
            "R1/R3/R5/R6/R8 random");
      if (($urandom % 16) == 0) begin
        @(negedge clk);
        settle_pending();
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    settle_pending();
    in_valid = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule